// File: doc/BRIEF.md
# Software-Triggerable Event Generator

This block gives a processor and a hardware trigger fabric a set of sixteen channels, each a plain "raise an event" action. A channel is fired either by a bus write of one to its task word or by a pulse on its hardware trigger line. Firing does exactly one thing: it sets that channel's sticky event flag. In the following clock it also emits a one-cycle event pulse that the trigger fabric can route onward to other tasks.

Software reads a channel's event word to see whether the flag is up. It clears the flag by writing zero to that word. Each channel has its own interrupt enable. All enabled, raised flags are merged onto a single level interrupt, so a handler has to scan the event words to find the source. The enable mask is changed through a pair of mask-write words, one that sets bits and one that clears them.

Word address map, with N = channel count: task words at 0..N-1, event words at N..2N-1, enable-set at 2N, enable-clear at 2N+1. Reads are combinational on the same cycle as the request. Writes take effect at the next rising clock edge.

Top module: `trig_event_unit`

## Requirements
- R1: After reset, every event word reads 0, the enable mask reads 0, irq_o is 0 and evt_pulse_o is all zero.
- R2: A bus write to task word n with data bit 0 = 1 sets flag n, visible from the next cycle. A write with bit 0 = 0 changes nothing.
- R3: A high level on hw_trig_i[n] during a clock cycle sets flag n, with no bus activity required.
- R4: evt_pulse_o[n] is high for exactly the one cycle after a cycle in which channel n was fired. A bus fire and a hardware fire of the same channel in the same cycle give a single one-cycle pulse.
- R5: Writing an event word with bit 0 = 0 clears its flag. Writing it with bit 0 = 1 leaves the flag unchanged, so only a fire can set a flag.
- R6: If a channel is fired and its event word is cleared in the same cycle, the flag ends up set.
- R7: Writing mask m to enable-set ORs m into the enable mask. Writing m to enable-clear removes the bits of m. Both words read back the current mask in bits N-1:0.
- R8: irq_o is a level equal to the OR over all channels of (flag AND enable). It stays high until every enabled flag is cleared or disabled.
- R9: Task words always read 0. An event word reads 1 in bit 0 while its flag is set and 0 otherwise, and the upper bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address (6 bits at default) |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational, valid when a read is requested |
| hw_trig_i | input | N_CH | Hardware task triggers, one per channel |
| evt_pulse_o | output | N_CH | One-cycle event pulses, one per channel |
| irq_o | output | 1 | Merged interrupt level |

## Verification
The properties assume a single-cycle bus. The flags are then driven only by the fire and clear terms decoded from the current request and trigger lines, and the enable mask moves only on a bus write. The properties also assume the hardware trigger lines are sampled once per clock, with no glitch-level meaning.

The stimulus applies every request and trigger change just after a rising edge and holds it for the full cycle. Each access lasts one cycle, so the cycle-exact pulse and flag relations in the properties are well defined. The collision cases are driven inside that same discipline: a bus fire together with a hardware fire, and a clear together with a fire.

// File: rtl/teu_pkg.sv
package teu_pkg;
  // region = upper two word-address bits
  typedef enum logic [1:0] {
    RGN_TASK = 2'd0,
    RGN_EVT  = 2'd1,
    RGN_EN   = 2'd2,
    RGN_RSVD = 2'd3
  } rgn_e;

  localparam int unsigned EN_SET_IDX = 0;
  localparam int unsigned EN_CLR_IDX = 1;
endpackage

// File: rtl/teu_bus_if.sv
module teu_bus_if
  import teu_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int DATA_W = 32,
  localparam int CH_W   = $clog2(N_CH),
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_CH-1:0]   flag_i,
  input  logic [N_CH-1:0]   en_i,
  output logic [N_CH-1:0]   sw_fire_o,
  output logic [N_CH-1:0]   evt_clr_o,
  output logic [N_CH-1:0]   en_set_o,
  output logic [N_CH-1:0]   en_clr_o
);
  rgn_e            rgn;
  logic [CH_W-1:0] idx;
  logic [N_CH-1:0] sel;
  logic            wr, rd;
  logic            unused_wdata;

  assign rgn = rgn_e'(addr_i[ADDR_W-1 -: 2]);
  assign idx = addr_i[CH_W-1:0];
  assign sel = N_CH'(1) << idx;
  assign wr  = req_i & we_i;
  assign rd  = req_i & ~we_i;
  assign unused_wdata = ^wdata_i[DATA_W-1:N_CH];

  always_comb begin
    sw_fire_o = '0;
    evt_clr_o = '0;
    en_set_o  = '0;
    en_clr_o  = '0;
    if (wr) begin
      unique case (rgn)
        RGN_TASK: if (wdata_i[0])  sw_fire_o = sel;
        RGN_EVT:  if (!wdata_i[0]) evt_clr_o = sel;
        RGN_EN: begin
          if (idx == CH_W'(EN_SET_IDX)) en_set_o = wdata_i[N_CH-1:0];
          if (idx == CH_W'(EN_CLR_IDX)) en_clr_o = wdata_i[N_CH-1:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (rgn)
        RGN_EVT: rdata_o = DATA_W'(flag_i[idx]);
        RGN_EN:  if (idx == CH_W'(EN_SET_IDX) || idx == CH_W'(EN_CLR_IDX))
                   rdata_o = DATA_W'(en_i);
        default: rdata_o = '0;  // task words read zero
      endcase
    end
  end
endmodule

// File: rtl/teu_channel.sv
module teu_channel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_fire_i,
  input  logic hw_fire_i,
  input  logic clr_i,
  output logic flag_o,
  output logic pulse_o
);
  logic fire;
  logic flag_q, pulse_q;

  assign fire = sw_fire_i | hw_fire_i;  // merged: one set, one pulse

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (fire)       flag_q <= 1'b1;  // set beats clear
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/teu_irq_merge.sv
module teu_irq_merge #(
  parameter int N_CH = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] en_set_i,
  input  logic [N_CH-1:0] en_clr_i,
  input  logic [N_CH-1:0] flag_i,
  output logic [N_CH-1:0] en_o,
  output logic            irq_o
);
  logic [N_CH-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q & ~en_clr_i) | en_set_i;
  end

  assign en_o  = en_q;
  assign irq_o = |(flag_i & en_q);
endmodule

// File: rtl/trig_event_unit.sv
module trig_event_unit #(
  parameter int N_CH   = 16,
  parameter int DATA_W = 32,
  localparam int CH_W   = $clog2(N_CH),
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [N_CH-1:0]   hw_trig_i,
  output logic [N_CH-1:0]   evt_pulse_o,
  output logic              irq_o
);
  logic [N_CH-1:0] flag_w, en_w;
  logic [N_CH-1:0] sw_fire_w, evt_clr_w, en_set_w, en_clr_w;

  teu_bus_if #(.N_CH(N_CH), .DATA_W(DATA_W)) u_bus (
    .req_i     (bus_req_i),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .flag_i    (flag_w),
    .en_i      (en_w),
    .sw_fire_o (sw_fire_w),
    .evt_clr_o (evt_clr_w),
    .en_set_o  (en_set_w),
    .en_clr_o  (en_clr_w)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    teu_channel u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sw_fire_i (sw_fire_w[g]),
      .hw_fire_i (hw_trig_i[g]),
      .clr_i     (evt_clr_w[g]),
      .flag_o    (flag_w[g]),
      .pulse_o   (evt_pulse_o[g])
    );
  end

  teu_irq_merge #(.N_CH(N_CH)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_set_i (en_set_w),
    .en_clr_i (en_clr_w),
    .flag_i   (flag_w),
    .en_o     (en_w),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/teu_checker.sv
module teu_checker #(
  parameter int N_CH = 16,
  localparam int CH_W   = $clog2(N_CH),
  localparam int ADDR_W = CH_W + 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wdata0_i,
  input logic [N_CH-1:0]   hw_trig_i,
  input logic [N_CH-1:0]   evt_pulse_o,
  input logic              irq_o,
  input logic [N_CH-1:0]   flags,
  input logic [N_CH-1:0]   en
);
  logic            past_ok;
  logic [N_CH-1:0] fire_m;
  logic            bus_wr;

  assign bus_wr = req_i && we_i;
  assign fire_m = hw_trig_i |
                  ((bus_wr && addr_i[ADDR_W-1 -: 2] == 2'd0 && wdata0_i)
                   ? (N_CH'(1) << addr_i[CH_W-1:0]) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r4_pulse_follows_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> evt_pulse_o == $past(fire_m));

  a_r5_flag_rises_only_on_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((flags & ~$past(flags) & ~$past(fire_m)) == '0));

  a_r6_fire_always_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((flags & $past(fire_m)) == $past(fire_m)));

  a_r7_mask_moves_on_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(bus_wr)) |-> en == $past(en));

  a_r8_irq_is_enabled_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(flags & en)));
endmodule

bind trig_event_unit teu_checker #(.N_CH(N_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (bus_req_i),
  .we_i        (bus_we_i),
  .addr_i      (bus_addr_i),
  .wdata0_i    (bus_wdata_i[0]),
  .hw_trig_i   (hw_trig_i),
  .evt_pulse_o (evt_pulse_o),
  .irq_o       (irq_o),
  .flags       (flag_w),
  .en          (en_w)
);

// File: tb/trig_event_unit_tb.sv
`timescale 1ns/1ps
module trig_event_unit_tb;
  localparam int N      = 16;
  localparam int DW     = 32;
  localparam int CH_W   = $clog2(N);
  localparam int ADDR_W = CH_W + 2;

  typedef struct {
    int          when;
    int          kind;   // 0 rdata, 1 irq, 2 pulse
    string       tag;
    logic [31:0] exp;
  } item_t;

  logic              clk = 0, rst_ni = 0;
  logic              bus_req_i = 0, bus_we_i = 0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic [DW-1:0]     bus_wdata_i = '0;
  logic [DW-1:0]     bus_rdata_o;
  logic [N-1:0]      hw_trig_i = '0;
  logic [N-1:0]      evt_pulse_o;
  logic              irq_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  item_t q[$];
  logic [N-1:0] m_flag = '0, m_en = '0;

  trig_event_unit #(.N_CH(N), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .hw_trig_i(hw_trig_i), .evt_pulse_o(evt_pulse_o), .irq_o(irq_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [ADDR_W-1:0] a_task(int n); return ADDR_W'(n); endfunction
  function automatic logic [ADDR_W-1:0] a_evt(int n);  return ADDR_W'(N + n); endfunction
  localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(2*N);
  localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(2*N + 1);

  function automatic logic [31:0] model_read(logic [ADDR_W-1:0] a);
    int v = int'(a);
    if (v < N)                     return 32'd0;
    if (v < 2*N)                   return {31'd0, m_flag[v-N]};
    if (v == 2*N || v == 2*N + 1)  return 32'(m_en);
    return 32'd0;
  endfunction

  function automatic void push(int w, int k, string t, logic [31:0] e);
    item_t it;
    it.when = w; it.kind = k; it.tag = t; it.exp = e;
    q.push_back(it);
  endfunction

  // driver: one cycle of stimulus, reference update, expected items
  task automatic drive(input logic req, input logic we, input logic [ADDR_W-1:0] a,
                       input logic [31:0] d, input logic [N-1:0] hw, input string tag);
    logic [N-1:0] fire, clr;
    int v;
    @(posedge clk); #1;
    bus_req_i = req; bus_we_i = we; bus_addr_i = a; bus_wdata_i = d; hw_trig_i = hw;
    v = int'(a);
    if (req && !we) push(cyc, 0, tag, model_read(a));
    fire = hw; clr = '0;
    if (req && we) begin
      if (v < N) begin
        if (d[0]) fire[v] = 1'b1;
      end else if (v < 2*N) begin
        if (!d[0]) clr[v-N] = 1'b1;
      end else if (v == 2*N) m_en = m_en | d[N-1:0];
      else if (v == 2*N + 1) m_en = m_en & ~d[N-1:0];
    end
    m_flag = (m_flag & ~clr) | fire;
    push(cyc + 1, 2, "R4", 32'(fire));
    push(cyc + 1, 1, "R8", {31'd0, |(m_flag & m_en)});
  endtask

  task automatic idle();                                   drive(0, 0, '0, 0, '0, "-"); endtask
  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d); drive(1, 1, a, d, '0, "-"); endtask
  task automatic rd(logic [ADDR_W-1:0] a, string t);       drive(1, 0, a, 0, '0, t);    endtask

  // monitor: pops and compares at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].when <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = bus_rdata_o;
        1:       act = {31'd0, irq_o};
        default: act = 32'(evt_pulse_o);
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s cyc=%0d kind=%0d actual=%h expected=%h", it.tag, cyc, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1;
    // R1: reset state
    @(negedge clk);
    n_cmp++;
    if (irq_o !== 1'b0 || evt_pulse_o !== '0) begin
      n_bad++;
      $display("FAIL R1 actual irq=%b pulse=%h expected irq=0 pulse=0", irq_o, evt_pulse_o);
    end
    for (int i = 0; i < N; i++) rd(a_evt(i), "R1");
    rd(A_ENSET, "R1");
    rd(A_ENCLR, "R1");

    // R2/R9: software fire, task reads zero
    wr(a_task(3), 32'd1);
    rd(a_task(3), "R9");
    rd(a_evt(3), "R2");
    wr(a_task(5), 32'd0);
    wr(a_task(6), 32'd2);
    rd(a_evt(5), "R2");
    rd(a_evt(6), "R2");

    // R3: hardware fire, two channels at once
    drive(0, 0, '0, 0, 16'h8001, "R3");
    idle();
    rd(a_evt(0), "R3");
    rd(a_evt(15), "R3");
    rd(a_evt(1), "R3");

    // R4: coincident bus + hardware fire on channel 7, then idle checks pulse drop
    drive(1, 1, a_task(7), 32'd1, 16'h0080, "R4");
    idle();
    idle();

    // R7: enable set/clear and readback
    wr(A_ENSET, 32'h0000_0088);
    rd(A_ENCLR, "R7");
    wr(A_ENCLR, 32'h0000_0008);
    rd(A_ENSET, "R7");

    // R8: irq follows the enabled flag only
    idle();
    wr(a_evt(7), 32'd0);
    idle();
    wr(A_ENSET, 32'h0000_0001);
    idle();
    wr(A_ENCLR, 32'h0000_0001);
    idle();

    // R5: clear works, writing one does not set
    wr(a_evt(3), 32'd0);
    rd(a_evt(3), "R5");
    wr(a_evt(3), 32'd1);
    rd(a_evt(3), "R5");
    wr(a_evt(0), 32'd1);
    rd(a_evt(0), "R5");

    // R6: fire and clear in the same cycle
    drive(1, 1, a_evt(9), 32'd0, 16'h0200, "R6");
    rd(a_evt(9), "R6");
    wr(A_ENSET, 32'h0000_0200);
    idle();

    // hardware burst on every channel, then sweep all event words
    drive(0, 0, '0, 0, 16'hFFFF, "R3");
    for (int i = 0; i < N; i += 2) wr(a_evt(i), 32'd0);
    for (int i = 0; i < N; i++) rd(a_evt(i), "R9");
    idle();
    idle();
    repeat (2) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule